// File: doc/BRIEF.md
# Double-Buffered DAC Data Latch

This block is the digital front end of an 8-bit multiplying converter. A data byte passes through two cascaded level-sensitive stores before it reaches the converter core. The first is an input store, opened by a chip-select/write-strobe/latch-enable qualifier. The second is a converter store, opened by a second write strobe together with a transfer line. A host can load a new byte into the input store while the core still converts the previous one. It then moves every loaded byte across at once by pulsing the transfer controls.

The same hardware gives three usage modes, chosen only by how the control pins are tied. In double-buffered use both stores are strobed separately. In single-buffered use the second store's controls are tied open, so one write pulse updates the output. In flow-through use every control is tied open, so the output tracks the data bus. The stores are modelled as level-sensitive storage sampled by a fast system clock, and a stored value shows on the output one clock after it is sampled. When both stores are closed and the data bus still toggles, the block raises a one-cycle activity flag. This flag stands in for the current spike that such switching would cause in a real converter.

Top module: `dbuf_dac_latch`

## Requirements
- R1: The input store takes the bus value at a clock edge only when `ile` is 1, `cs_n` is 0 and `wr1_n` is 0; otherwise it keeps its content.
- R2: The converter store, whose content is `code`, takes a new value only at an edge where `wr2_n` and `xfer_n` are both 0; at any other edge `code` stays unchanged one cycle later.
- R3: Double-buffered use: a byte loaded into the input store appears on `code` one cycle after an edge at which only the converter store is open, independent of bus activity since the load.
- R4: Flow-through use: with `cs_n`, `wr1_n`, `wr2_n`, `xfer_n` all 0 and `ile` 1, `code` equals the bus value sampled at the previous edge.
- R5: Single-buffered use: with `wr2_n`, `xfer_n` at 0 and `ile` 1, a `cs_n`/`wr1_n` low pulse updates `code` one cycle after each edge inside the pulse. After the strobe rises, `code` keeps the value sampled at the last edge the strobe was low.
- R6: `feedthru` is 1 for exactly the cycle after an edge at which both stores are closed and `din` differs from its value at the previous edge; `code` does not change then.
- R7: `feedthru` stays 0 in the cycle after any edge at which either store is open.
- R8: While `rst_n` is 0, `code` and `feedthru` are 0. The release of reset is synchronised over two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select qualifying the first strobe |
| wr1_n | input | 1 | Active-low write strobe of the input store |
| wr2_n | input | 1 | Active-low write strobe of the converter store |
| xfer_n | input | 1 | Active-low transfer line of the converter store |
| ile | input | 1 | Active-high enable of the input store |
| din | input | 8 | Data bus |
| code | output | 8 | Code held in the converter store |
| feedthru | output | 1 | One-cycle flag: bus toggled while both stores were closed |

## Verification
The main function is tried with three directed mode patterns: a separate load followed by a transfer, a single strobe with the second store tied open, and fully open flow-through. These patterns show whether each store's qualifier is decoded on its own and whether the two stores cascade in the same cycle. A qualifier with one term missing, such as `ile` low, tells apart a correct full decode from a partial one. Long random runs mix all five controls with changing data, so that hold, transfer and feedthrough cases meet in every order. A reference model in the bench checks each cycle against them.

// File: rtl/dac_latch_pkg.sv
package dac_latch_pkg;
  typedef struct packed {
    logic in_open;
    logic dac_open;
  } gate_t;
endpackage

// File: rtl/dl_ctrl_decode.sv
module dl_ctrl_decode
  import dac_latch_pkg::*;
(
  input  logic  cs_n,
  input  logic  wr1_n,
  input  logic  wr2_n,
  input  logic  xfer_n,
  input  logic  ile,
  output gate_t gate
);
  always_comb begin
    gate.in_open  = ile & ~cs_n & ~wr1_n;
    gate.dac_open = ~wr2_n & ~xfer_n;
  end
endmodule

// File: rtl/dl_latch_stage.sv
module dl_latch_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         open,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (open) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/dl_feedthru_det.sv
module dl_feedthru_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         quiet,
  output logic         pulse
);
  logic [W-1:0] prev_q;
  logic         pulse_nxt;

  always_comb begin
    pulse_nxt = quiet && (din != prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pulse  <= 1'b0;
    end else begin
      prev_q <= din;
      pulse  <= pulse_nxt;
    end
  end
endmodule

// File: rtl/dbuf_dac_latch.sv
module dbuf_dac_latch
  import dac_latch_pkg::*;
#(
  parameter int DW          = 8,
  parameter int RST_STAGES  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wr1_n,
  input  logic          wr2_n,
  input  logic          xfer_n,
  input  logic          ile,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] code,
  output logic          feedthru
);
  localparam int SL = (RST_STAGES < 1) ? 1 : RST_STAGES;

  logic [SL-1:0] rst_pipe;
  logic          rst_sync_n;
  gate_t         gate;
  logic [DW-1:0] in_q;
  logic [DW-1:0] dac_d;
  logic          quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SL-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SL-1];

  dl_ctrl_decode u_dec (
    .cs_n  (cs_n),
    .wr1_n (wr1_n),
    .wr2_n (wr2_n),
    .xfer_n(xfer_n),
    .ile   (ile),
    .gate  (gate)
  );

  dl_latch_stage #(.W(DW)) u_in_stage (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .open (gate.in_open),
    .d    (din),
    .q    (in_q)
  );

  always_comb begin
    dac_d = gate.in_open ? din : in_q;
  end

  dl_latch_stage #(.W(DW)) u_dac_stage (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .open (gate.dac_open),
    .d    (dac_d),
    .q    (code)
  );

  assign quiet = ~gate.in_open & ~gate.dac_open;

  dl_feedthru_det #(.W(DW)) u_ft (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .din  (din),
    .quiet(quiet),
    .pulse(feedthru)
  );
endmodule

// File: rtl/dbuf_dac_latch_chk.sv
module dbuf_dac_latch_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          wr1_n,
  input logic          wr2_n,
  input logic          xfer_n,
  input logic          ile,
  input logic [DW-1:0] din,
  input logic [DW-1:0] code,
  input logic          feedthru
);
  logic c_in, c_dac, c_flow;
  assign c_in   = ile && !cs_n && !wr1_n;
  assign c_dac  = !wr2_n && !xfer_n;
  assign c_flow = c_in && c_dac;

  a_r2_closed_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !c_dac |=> $stable(code));

  a_r4_flow: assert property (@(posedge clk) disable iff (!rst_n)
    c_flow |=> (code == $past(din)));

  a_r6_ft_cause: assert property (@(posedge clk) disable iff (!rst_n)
    feedthru |-> $past(!c_in && !c_dac));

  a_r7_ft_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (c_in || c_dac) |=> !feedthru);

  a_r8_reset: assert property (@(posedge clk)
    !rst_n |-> (code == '0 && !feedthru));
endmodule

bind dbuf_dac_latch dbuf_dac_latch_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .cs_n    (cs_n),
  .wr1_n   (wr1_n),
  .wr2_n   (wr2_n),
  .xfer_n  (xfer_n),
  .ile     (ile),
  .din     (din),
  .code    (code),
  .feedthru(feedthru)
);

// File: tb/dbuf_dac_latch_bench.sv
module dbuf_dac_latch_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, wr1_n, wr2_n, xfer_n, ile;
  logic [7:0] din;
  logic [7:0] code;
  logic       feedthru;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [7:0] m_in, m_code, m_prev;
  logic       m_ft;

  always #5 clk = ~clk;

  dbuf_dac_latch u_dbuf_dac_latch (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr1_n(wr1_n), .wr2_n(wr2_n),
    .xfer_n(xfer_n), .ile(ile), .din(din), .code(code), .feedthru(feedthru)
  );

  function automatic logic f_in_open(logic l, logic c, logic w);
    return l & ~c & ~w;
  endfunction

  function automatic logic f_dac_open(logic w, logic x);
    return ~w & ~x;
  endfunction

  task automatic check(string tag, logic [7:0] ac, logic [7:0] ec, logic af, logic ef);
    n_chk++;
    if (ac !== ec || af !== ef) begin
      n_bad++;
      $display("FAIL %s: code=%02h ft=%0b expected code=%02h ft=%0b", tag, ac, af, ec, ef);
    end
  endtask

  task automatic step(string tag, logic c, logic w1, logic w2, logic x, logic l, logic [7:0] d);
    logic io, dop;
    cs_n = c; wr1_n = w1; wr2_n = w2; xfer_n = x; ile = l; din = d;
    @(posedge clk);
    io  = f_in_open(l, c, w1);
    dop = f_dac_open(w2, x);
    m_ft = (d != m_prev) && !io && !dop;
    if (dop) m_code = io ? d : m_in;
    if (io)  m_in = d;
    m_prev = d;
    @(negedge clk);
    check(tag, code, m_code, feedthru, m_ft);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; cs_n = 1; wr1_n = 1; wr2_n = 1; xfer_n = 1; ile = 0; din = 8'h00;
    m_in = 0; m_code = 0; m_prev = 0; m_ft = 0;
    repeat (3) @(negedge clk);
    din = 8'hA5; cs_n = 0; wr1_n = 0; wr2_n = 0; xfer_n = 0; ile = 1;
    @(negedge clk);
    check("R8 reset", code, 8'h00, feedthru, 1'b0);
    din = 8'h00; cs_n = 1; wr1_n = 1; wr2_n = 1; xfer_n = 1; ile = 0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 release", code, 8'h00, feedthru, 1'b0);

    // R3 double-buffered: load, bus churn, then transfer
    step("R1 load",       0, 0, 1, 1, 1, 8'h3C);
    step("R6 churn",      1, 1, 1, 1, 1, 8'hFF);
    step("R6 churn",      1, 1, 1, 1, 1, 8'h01);
    step("R6 steady",     1, 1, 1, 1, 1, 8'h01);
    step("R3 transfer",   1, 1, 0, 0, 0, 8'h77);
    check("R3 value", code, 8'h3C, feedthru, 1'b0);
    step("R2 closed",     1, 1, 1, 1, 0, 8'h55);
    // R1 ignored: ile low blocks the input store
    step("R1 ile low",    0, 0, 1, 1, 0, 8'h99);
    step("R1 xfer",       1, 1, 0, 0, 0, 8'h99);
    check("R1 kept", code, 8'h3C, feedthru, 1'b0);
    // R2: one term of transfer qualifier missing
    step("R2 half",       0, 0, 0, 1, 1, 8'h12);
    step("R2 half",       0, 0, 1, 0, 1, 8'h34);
    // R5 single-buffered
    step("R5 strobe",     0, 0, 0, 0, 1, 8'hC3);
    step("R5 strobe",     0, 0, 0, 0, 1, 8'hC4);
    step("R5 rise",       1, 1, 0, 0, 1, 8'h10);
    check("R5 kept", code, 8'hC4, feedthru, 1'b0);
    // R4 flow-through
    for (int i = 0; i < 8; i++) step("R4 flow", 0, 0, 0, 0, 1, 8'(i * 37 + 5));
    check("R4 value", code, 8'(7 * 37 + 5), feedthru, 1'b0);
    // R7: toggling bus while a store is open
    step("R7 open", 1, 1, 0, 0, 0, 8'hE0);
    step("R7 open", 0, 0, 1, 1, 1, 8'hE1);

    for (int i = 0; i < 3000; i++) begin
      logic [4:0] r;
      r = 5'($urandom);
      step("R2 random", r[0], r[1] & r[4], r[2], r[3] & r[4], ~r[0] | r[1],
           ($urandom % 4 == 0) ? din : 8'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule